// File: doc/BRIEF.md
# Dual-Supply Reset Supervisor

This block turns already-digitized supply comparator results into a system reset and two failure flags. It holds the reset asserted from power-on. It releases the reset only after the primary supply has stayed good for a programmable number of clock cycles. It asserts the reset again whenever the primary supply sags below its trip level, the supply falls below the minimum level, or the synchronized manual-reset input is pulled low.

A second, independent comparator result drives a secondary-fail flag. That flag follows the secondary comparator with one register of latency and no release delay. It can be ORed into the system reset or used as an early-warning interrupt.

A two-bit select picks one of four release delays from a parameter table. The delay is latched when a period starts, so a change to the select during a count applies from the next period.

Top module: `supply_reset_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `sys_rst_o` is 1, `sys_rst_no` is 0, and both `pri_fail_o` and `sec_fail_o` are 0.
- R2: The hold condition is true when `pri_ok_i` is 0, `vmin_ok_i` is 0 or `man_rst_ni` is 0. Once it clears, `sys_rst_o` falls on exactly the N-th rising edge that sees it clear. N is DLY0, DLY1, DLY2 or DLY3 for `dly_sel_i` equal to 0, 1, 2 or 3.
- R3: When `pri_ok_i` is 0 and `vmin_ok_i` is 1, both `sys_rst_o` and `pri_fail_o` are 1 after the next rising edge.
- R4: `pri_fail_o` clears on the same edge on which `sys_rst_o` is released, and not before.
- R5: While `man_rst_ni` is 0, `sys_rst_o` is 1 from the next edge on. After it returns to 1, the full delay N must elapse before release.
- R6: `sec_fail_o` equals `vmin_ok_i AND NOT sec_ok_i` as sampled at the previous rising edge. It has no release delay.
- R7: When `vmin_ok_i` is 0, the next edge forces `sys_rst_o` to 1 and clears both fail flags.
- R8: Any return of the hold condition while the delay counts restarts the count from zero.
- R9: `dly_sel_i` is sampled on the first counting edge of a period. Changes made later in that period do not alter its length.
- R10: `sys_rst_no` is the complement of `sys_rst_o` in every cycle.
- R11: A manual press alone does not set `pri_fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pri_ok_i | input | 1 | Primary supply above trip 1 |
| sec_ok_i | input | 1 | Secondary monitor above trip 2 |
| vmin_ok_i | input | 1 | Supply above the minimum (about 1 V) level |
| man_rst_ni | input | 1 | Synchronized manual reset, active low |
| dly_sel_i | input | 2 | Release delay select (index into DLY0..DLY3) |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |
| pri_fail_o | output | 1 | Primary supply failure flag, active high |
| sec_fail_o | output | 1 | Secondary monitor failure flag, active high |

## Verification
The assertions assume that all comparator inputs and the manual input are synchronous to `clk` and free of glitches narrower than a cycle. They also assume every table entry is at least one cycle. The release check only bounds the good run from below by the smallest table entry, because the select is free to change at any time. The bench drives every input on the falling edge. It uses small table values so that each select, each hold source and every restart point in a period can be swept.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned NUM_DLY = 1 << SEL_W;

    typedef struct packed {
        logic rst;
        logic pfail;
    } sup_state_t;

    localparam sup_state_t SUP_RESET = '{rst: 1'b1, pfail: 1'b0};
endpackage

// File: rtl/sup_dly_counter.sv
module sup_dly_counter #(
    parameter int unsigned DLY0 = 16,
    parameter int unsigned DLY1 = 64,
    parameter int unsigned DLY2 = 256,
    parameter int unsigned DLY3 = 1024,
    localparam int unsigned MAXA = (DLY0 > DLY1) ? DLY0 : DLY1,
    localparam int unsigned MAXB = (DLY2 > DLY3) ? DLY2 : DLY3,
    localparam int unsigned MAXD = (MAXA > MAXB) ? MAXA : MAXB,
    localparam int unsigned CW   = $clog2(MAXD + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic [sup_pkg::SEL_W-1:0] sel_i,
    output logic                     done_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } cnt_state_t;

    cnt_state_t    st_d, st_q;
    logic [CW-1:0] sel_lim;
    logic [CW-1:0] lim_eff;

    always_comb begin
        unique case (sel_i)
            2'd0:    sel_lim = CW'(DLY0);
            2'd1:    sel_lim = CW'(DLY1);
            2'd2:    sel_lim = CW'(DLY2);
            default: sel_lim = CW'(DLY3);
        endcase
    end

    always_comb begin
        st_d    = st_q;
        lim_eff = (st_q.cnt == '0) ? sel_lim : st_q.lim;
        done_o  = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.lim = lim_eff;
            if (st_q.cnt == lim_eff - CW'(1)) begin
                done_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sup_sec_monitor.sv
module sup_sec_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_ok_i,
    input  logic vmin_ok_i,
    output logic fail_o
);
    logic fail_d, fail_q;

    always_comb begin
        fail_d = vmin_ok_i & ~sec_ok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= fail_d;
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor #(
    parameter int unsigned DLY0 = 16,
    parameter int unsigned DLY1 = 64,
    parameter int unsigned DLY2 = 256,
    parameter int unsigned DLY3 = 1024,
    localparam int unsigned MINA = (DLY0 < DLY1) ? DLY0 : DLY1,
    localparam int unsigned MINB = (DLY2 < DLY3) ? DLY2 : DLY3,
    localparam int unsigned MIN_DLY = (MINA < MINB) ? MINA : MINB
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_ok_i,
    input  logic       sec_ok_i,
    input  logic       vmin_ok_i,
    input  logic       man_rst_ni,
    input  logic [1:0] dly_sel_i,
    output logic       sys_rst_o,
    output logic       sys_rst_no,
    output logic       pri_fail_o,
    output logic       sec_fail_o
);
    import sup_pkg::*;

    sup_state_t st_d, st_q;
    logic       hold;
    logic       done;

    assign hold = ~pri_ok_i | ~vmin_ok_i | ~man_rst_ni;

    sup_dly_counter #(
        .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(hold | ~st_q.rst),
        .sel_i  (dly_sel_i),
        .done_o (done)
    );

    sup_sec_monitor u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_ok_i (sec_ok_i),
        .vmin_ok_i(vmin_ok_i),
        .fail_o   (sec_fail_o)
    );

    always_comb begin
        st_d = st_q;
        if (hold)      st_d.rst = 1'b1;
        else if (done) st_d.rst = 1'b0;

        if (!vmin_ok_i)     st_d.pfail = 1'b0;
        else if (!pri_ok_i) st_d.pfail = 1'b1;
        else if (done)      st_d.pfail = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SUP_RESET;
        else        st_q <= st_d;
    end

    assign sys_rst_o  = st_q.rst;
    assign sys_rst_no = ~st_q.rst;
    assign pri_fail_o = st_q.pfail;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int unsigned MIN_DLY = 1
) (
    input logic clk,
    input logic rst_n,
    input logic pri_ok_i,
    input logic sec_ok_i,
    input logic vmin_ok_i,
    input logic man_rst_ni,
    input logic sys_rst_o,
    input logic pri_fail_o,
    input logic sec_fail_o
);
    logic [31:0] run_q;
    logic        good;

    assign good = pri_ok_i & vmin_ok_i & man_rst_ni;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (!good)             run_q <= '0;
        else if (run_q != '1)       run_q <= run_q + 32'd1;
    end

    assert_release_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> run_q >= MIN_DLY);

    assert_brownout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_ok_i && vmin_ok_i) |=> (sys_rst_o && pri_fail_o));

    assert_pfail_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pri_fail_o) |-> ($fell(sys_rst_o) || !$past(vmin_ok_i)));

    assert_manual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !man_rst_ni |=> sys_rst_o);

    assert_sec_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vmin_ok_i && !sec_ok_i) |=> sec_fail_o);

    assert_sec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vmin_ok_i && sec_ok_i) |=> !sec_fail_o);

    assert_low_vcc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vmin_ok_i |=> (sys_rst_o && !pri_fail_o && !sec_fail_o));

    assert_no_pfail_on_press_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_ok_i && !pri_fail_o) |=> !pri_fail_o);
endmodule

bind supply_reset_supervisor sup_checker #(.MIN_DLY(MIN_DLY)) u_sup_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_ok_i  (pri_ok_i),
    .sec_ok_i  (sec_ok_i),
    .vmin_ok_i (vmin_ok_i),
    .man_rst_ni(man_rst_ni),
    .sys_rst_o (sys_rst_o),
    .pri_fail_o(pri_fail_o),
    .sec_fail_o(sec_fail_o)
);

// File: tb/test_supply_reset_supervisor.sv
module test_supply_reset_supervisor;
    localparam int unsigned D0 = 3, D1 = 5, D2 = 8, D3 = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_ok = 1'b1, sec_ok = 1'b1, vmin_ok = 1'b1, man_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic sys_rst, sys_rst_n, pri_fail, sec_fail;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    supply_reset_supervisor #(.DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3)) i_supply_reset_supervisor (
        .clk(clk), .rst_n(rst_n), .pri_ok_i(pri_ok), .sec_ok_i(sec_ok),
        .vmin_ok_i(vmin_ok), .man_rst_ni(man_n), .dly_sel_i(sel),
        .sys_rst_o(sys_rst), .sys_rst_no(sys_rst_n),
        .pri_fail_o(pri_fail), .sec_fail_o(sec_fail)
    );

    function automatic int unsigned dly_of(input logic [1:0] s);
        case (s)
            2'd0: return D0;
            2'd1: return D1;
            2'd2: return D2;
            default: return D3;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
        // R10: complement holds in every sampled cycle
        n_chk++;
        if (sys_rst_n !== ~sys_rst) begin
            n_bad++;
            $display("FAIL R10: actual %b expected %b", sys_rst_n, ~sys_rst);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expect reset held for n-1 edges, released at edge n (all inputs good).
    task automatic expect_release(input int unsigned n, input logic pf, input string tag);
        for (int k = 1; k <= int'(n); k++) begin
            step();
            chk(sys_rst, (k < int'(n)), tag);
            chk(pri_fail, (k < int'(n)) ? pf : 1'b0, "R4");
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(sys_rst, 1'b1, "R1");
        chk(pri_fail, 1'b0, "R1");
        chk(sec_fail, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        chk(sys_rst, 1'b1, "R1");
        expect_release(dly_of(2'd0), 1'b0, "R2");

        // Brownout sweep over every select
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            pri_ok = 1'b0;
            step();
            chk(sys_rst, 1'b1, "R3");
            chk(pri_fail, 1'b1, "R3");
            step();
            pri_ok = 1'b1;
            expect_release(dly_of(2'(s)), 1'b1, "R2");
        end

        // Manual press per select; no primary fail expected
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            man_n = 1'b0;
            for (int k = 0; k < 3; k++) begin
                step();
                chk(sys_rst, 1'b1, "R5");
                chk(pri_fail, 1'b0, "R11");
            end
            man_n = 1'b1;
            expect_release(dly_of(2'(s)), 1'b0, "R5");
        end

        // Restart at every point of a period (select 2)
        sel = 2'd2;
        for (int p = 1; p < int'(D2); p++) begin
            man_n = 1'b0;
            step();
            man_n = 1'b1;
            for (int k = 0; k < p; k++) begin
                step();
                chk(sys_rst, 1'b1, "R8");
            end
            if (p % 2 == 0) pri_ok = 1'b0; else man_n = 1'b0;
            step();
            chk(sys_rst, 1'b1, "R8");
            pri_ok = 1'b1; man_n = 1'b1;
            expect_release(D2, (p % 2 == 0), "R8");
        end

        // Select change mid-period does not alter the running period
        sel = 2'd3;
        man_n = 1'b0;
        step();
        man_n = 1'b1;
        step();
        chk(sys_rst, 1'b1, "R9");
        sel = 2'd0;
        expect_release(D3 - 1, 1'b0, "R9");
        // Next period uses the new select
        man_n = 1'b0;
        step();
        man_n = 1'b1;
        expect_release(D0, 1'b0, "R9");

        // Secondary monitor: all combinations, one edge latency
        for (int c = 0; c < 8; c++) begin
            vmin_ok = c[0];
            sec_ok  = c[1];
            step();
            chk(sec_fail, c[0] & ~c[1], "R6");
            if (!c[0]) begin
                chk(sys_rst, 1'b1, "R7");
                chk(pri_fail, 1'b0, "R7");
            end
            sec_ok = c[2];
            step();
            chk(sec_fail, c[0] & ~c[2], "R6");
        end

        // Primary fail then drop below minimum clears the flag
        vmin_ok = 1'b1; sec_ok = 1'b1; pri_ok = 1'b0;
        step();
        chk(pri_fail, 1'b1, "R3");
        vmin_ok = 1'b0;
        step();
        chk(pri_fail, 1'b0, "R7");
        chk(sys_rst, 1'b1, "R7");
        chk(sec_fail, 1'b0, "R7");
        vmin_ok = 1'b1; pri_ok = 1'b1; sel = 2'd1;
        expect_release(D1, 1'b0, "R2");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule